// File: doc/BRIEF.md
# Frame-Synchronous Byte Descrambler

This block takes a byte-wide optical transport frame stream that an upstream framer has already aligned, and removes the line scrambling from it. A frame-start strobe, qualified by a byte-valid strobe, marks the first alignment byte of each frame. The six alignment bytes at the head of the frame are forwarded unchanged. Every other byte is XORed with a keystream from a 16-bit linear feedback generator, and that includes the multiframe alignment byte that follows the alignment bytes. The generator is reloaded with all ones at the same frame position in every frame, so the keystream is tied to frame position and never runs freely.

A position counter follows the frame from byte to byte and advances only on valid bytes. When the frame boundary passes without a new frame-start, the counter wraps on its own. A frame-start that comes early realigns the counter at once. Until the first frame-start after reset, the block has no frame position, so it passes bytes through unchanged. Outputs appear one clock after their inputs, and the valid and frame-start strobes are delayed to match.

Top module: `dscr_top`

## Requirements
- R1: The keystream is the bit sequence b with b[0..15] all ones and b[n] = b[n-1] ^ b[n-3] ^ b[n-12] ^ b[n-16], which is the generator 1 + x + x^3 + x^12 + x^16. Frame byte position p (p ≥ 6) is XORed with bits b[8(p-6)] to b[8(p-6)+7]. The first of these bits lands on data bit 7.
- R2: Frame byte positions 0 to 5 are the alignment bytes, where position 0 is the byte that carries the frame-start. They are output unchanged.
- R3: Position 6 is the multiframe alignment byte and is descrambled like payload. Its key is 0xFF, so its output is the bitwise inverse of its input.
- R4: The keystream restarts from b[0] at position 6 of every frame.
- R5: Only bytes with valid high advance the frame position and the keystream. Idle cycles between them change neither.
- R6: outValid equals inValid delayed by one clock, and outData carries the processed byte in that same cycle. outData holds its value while outValid is low.
- R7: outFrameStart is (inValid and inFrameStart) delayed by one clock. A frame-start without valid has no effect on framing.
- R8: From reset until the first valid frame-start, every byte passes through unchanged.
- R9: After position ROWS*ROW_BYTES-1 the position wraps to 0 even when no frame-start arrives. The defaults are 4 rows of 4080 bytes.
- R10: A valid frame-start that arrives mid-frame forces that byte to position 0.
- R11: During reset and in the first cycle after it, outValid and outFrameStart are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| inData | input | DATA_W (8) | Scrambled byte in |
| inValid | input | 1 | inData holds a byte this cycle |
| inFrameStart | input | 1 | Byte is the first alignment byte of a frame |
| outData | output | DATA_W (8) | Descrambled byte |
| outValid | output | 1 | Delayed valid |
| outFrameStart | output | 1 | Delayed, valid-qualified frame-start |

## Verification
The bench builds the keystream from the recurrence as a plain bit array and tracks frame position with an integer. It compares every output on every clock against that model. Runs of all-zero input expose the raw keystream, so a wrong tap, a reversed bit order or a seed at the wrong position shows up as data that differs from byte 6 onward, or as corrupted alignment bytes. Random gaps in valid catch a generator that keeps stepping while idle. A frame boundary with no frame-start would show a counter that fails to wrap. An early frame-start would show a counter that ignores resync. A frame-start sent with valid low would show a design that wrongly realigns. Bytes sent before the first frame-start would come out altered if the design scrambled them while it had no frame position.

// File: rtl/dscr_pkg.sv
package dscr_pkg;

  localparam int GEN_W = 16;
  localparam logic [GEN_W-1:0] GEN_SEED = '1;

  // Control to datapath strobes for the current input byte.
  typedef struct packed {
    logic take;       // a byte is present this cycle
    logic bypass;     // forward unchanged
    logic seed;       // keystream restarts on this byte
    logic frameMark;  // byte is a qualified frame start
  } dscrStrobe_t;

  // One keystream step: the oldest bit leaves at the top and the new
  // bit is formed from taps 1, 3, 12, 16 back in the history.
  function automatic logic [GEN_W-1:0] genStep(input logic [GEN_W-1:0] s);
    return {s[GEN_W-2:0], s[15] ^ s[11] ^ s[2] ^ s[0]};
  endfunction

endpackage

// File: rtl/dscr_ctrl.sv
module dscr_ctrl
  import dscr_pkg::*;
#(
  parameter int ROWS      = 4,
  parameter int ROW_BYTES = 4080,
  parameter int FAS_BYTES = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inFrameStart,
  output dscrStrobe_t strobe
);

  localparam int FRAME_BYTES = ROWS * ROW_BYTES;
  localparam int POS_W       = $clog2(FRAME_BYTES);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BYTES - 1);
  localparam logic [POS_W-1:0] KEY_POS  = POS_W'(FAS_BYTES);

  logic [POS_W-1:0] posQ;
  logic [POS_W-1:0] curPos;
  logic             lockedQ;
  logic             fsHit;
  logic             lockedNow;

  assign fsHit     = inValid & inFrameStart;
  assign curPos    = fsHit ? '0 : posQ;
  assign lockedNow = lockedQ | fsHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posQ    <= '0;
      lockedQ <= 1'b0;
    end else if (inValid) begin
      posQ    <= (curPos == LAST_POS) ? '0 : curPos + 1'b1;
      lockedQ <= lockedNow;
    end
  end

  always_comb begin
    strobe.take      = inValid;
    strobe.frameMark = fsHit;
    strobe.bypass    = !lockedNow || (curPos < KEY_POS);
    strobe.seed      = lockedNow && (curPos == KEY_POS);
  end

endmodule

// File: rtl/dscr_datapath.sv
module dscr_datapath
  import dscr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dscrStrobe_t       strobe,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outFrameStart
);

  logic [GEN_W-1:0]  genQ;
  logic [GEN_W-1:0]  chain [DATA_W+1];
  logic [DATA_W-1:0] keyByte;

  assign chain[0] = strobe.seed ? GEN_SEED : genQ;

  for (genvar k = 0; k < DATA_W; k++) begin : g_bit
    assign keyByte[DATA_W-1-k] = chain[k][GEN_W-1];
    assign chain[k+1]          = genStep(chain[k]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      genQ          <= GEN_SEED;
      outData       <= '0;
      outValid      <= 1'b0;
      outFrameStart <= 1'b0;
    end else begin
      outValid      <= strobe.take;
      outFrameStart <= strobe.frameMark;
      if (strobe.take) begin
        if (strobe.bypass) begin
          outData <= inData;
        end else begin
          outData <= inData ^ keyByte;
          genQ    <= chain[DATA_W];
        end
      end
    end
  end

endmodule

// File: rtl/dscr_top.sv
module dscr_top
  import dscr_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ROWS      = 4,
  parameter int ROW_BYTES = 4080,
  parameter int FAS_BYTES = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              inFrameStart,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outFrameStart
);

  dscrStrobe_t strobe;

  dscr_ctrl #(
    .ROWS(ROWS), .ROW_BYTES(ROW_BYTES), .FAS_BYTES(FAS_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inFrameStart(inFrameStart), .strobe(strobe)
  );

  dscr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .outData(outData), .outValid(outValid), .outFrameStart(outFrameStart)
  );

endmodule

// File: rtl/dscr_checker.sv
module dscr_checker #(
  parameter int DATA_W    = 8,
  parameter int ROWS      = 4,
  parameter int ROW_BYTES = 4080,
  parameter int FAS_BYTES = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] inData,
  input logic              inValid,
  input logic              inFrameStart,
  input logic [DATA_W-1:0] outData,
  input logic              outValid,
  input logic              outFrameStart
);

  localparam int FRAME_BYTES = ROWS * ROW_BYTES;

  int   ckPos;
  logic ckSeen;
  logic started;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckPos   <= 0;
      ckSeen  <= 1'b0;
      started <= 1'b0;
    end else begin
      started <= 1'b1;
      if (inValid) begin
        if (inFrameStart) begin
          ckSeen <= 1'b1;
          ckPos  <= 1;
        end else begin
          ckPos  <= (ckPos == FRAME_BYTES - 1) ? 0 : ckPos + 1;
        end
      end
    end
  end

  // R6: valid follows one clock later
  a_r6_valid_delay: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r6_idle_delay: assert property (@(posedge clk) disable iff (!rstN)
    (started && !inValid) |=> !outValid);
  // R6: data held while idle
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (started && !inValid) |=> $stable(outData));
  // R7: frame-start aligned and qualified
  a_r7_fs_align: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inFrameStart) |=> outFrameStart);
  a_r7_fs_qual: assert property (@(posedge clk) disable iff (!rstN)
    outFrameStart |-> outValid);
  // R2: alignment bytes unchanged
  a_r2_fas_pass: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (inFrameStart || (ckSeen && ckPos < FAS_BYTES)))
      |=> outData == $past(inData));
  // R8: no framing yet, bytes unchanged
  a_r8_unlocked_pass: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inFrameStart && !ckSeen) |=> outData == $past(inData));
  // R3: multiframe byte inverted by an all-ones key
  a_r3_mfas_key: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inFrameStart && ckSeen && ckPos == FAS_BYTES)
      |=> outData == ~$past(inData));

endmodule

bind dscr_top dscr_checker #(
  .DATA_W(DATA_W), .ROWS(ROWS), .ROW_BYTES(ROW_BYTES), .FAS_BYTES(FAS_BYTES)
) u_chk (
  .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
  .inFrameStart(inFrameStart), .outData(outData), .outValid(outValid),
  .outFrameStart(outFrameStart)
);

// File: tb/sim_dscr_top.sv
`timescale 1ns/1ps
module sim_dscr_top;

  localparam int ROWS  = 4;
  localparam int RB    = 40;
  localparam int FAS   = 6;
  localparam int FRAME = ROWS * RB;
  localparam int NKEY  = (FRAME - FAS) * 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inFrameStart = 1'b0;
  logic [7:0] outData;
  logic       outValid;
  logic       outFrameStart;

  always #5 clk = ~clk;

  dscr_top #(.DATA_W(8), .ROWS(ROWS), .ROW_BYTES(RB), .FAS_BYTES(FAS)) u0 (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
    .inFrameStart(inFrameStart), .outData(outData), .outValid(outValid),
    .outFrameStart(outFrameStart)
  );

  int    nCmp = 0;
  int    nBad = 0;
  bit    ks [NKEY];
  string tag = "R11";
  bit    done = 0;

  // reference model state
  int         mPos = 0;
  bit         mLocked = 0;
  logic       expV = 0;
  logic       expFs = 0;
  logic [7:0] expD = '0;

  function automatic logic [7:0] keyAt(int p);
    logic [7:0] k;
    for (int i = 0; i < 8; i++) k[7-i] = ks[(p - FAS) * 8 + i];
    return k;
  endfunction

  // R1: keystream straight from the recurrence
  initial begin
    for (int n = 0; n < NKEY; n++)
      ks[n] = (n < 16) ? 1'b1 : (ks[n-1] ^ ks[n-3] ^ ks[n-12] ^ ks[n-16]);
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mPos = 0; mLocked = 0; expV = 0; expFs = 0;
    end else begin
      int p;
      expV  = inValid;
      expFs = inValid && inFrameStart;
      if (inValid) begin
        p = inFrameStart ? 0 : mPos;
        if (inFrameStart) mLocked = 1;
        expD = (!mLocked || p < FAS) ? inData : (inData ^ keyAt(p));
        mPos = (p == FRAME - 1) ? 0 : p + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      nCmp++;
      if (outValid !== expV || outFrameStart !== expFs ||
          (expV && outData !== expD)) begin
        nBad++;
        $display("FAIL %s: v/fs/d actual %b/%b/%h expected %b/%b/%h at %0t",
                 tag, outValid, outFrameStart, outData, expV, expFs, expD, $time);
      end
    end
  end

  task automatic drive(input logic [7:0] d, input logic v, input logic fs);
    @(negedge clk);
    inData = d; inValid = v; inFrameStart = fs;
  endtask

  task automatic sendFrame(input bit zeros, input bit gaps, input bit withFs, input int len);
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 3 == 0)) drive(8'($urandom), 1'b0, 1'b0);
      drive(zeros ? 8'h00 : 8'($urandom), 1'b1, withFs && i == 0);
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    tag = "R11";
    nCmp++;
    if (outValid !== 1'b0 || outFrameStart !== 1'b0) begin
      nBad++;
      $display("FAIL R11: actual %b/%b expected 0/0", outValid, outFrameStart);
    end
    rstN = 1'b1;
    tag = "R8";
    for (int i = 0; i < 25; i++) drive(8'($urandom), 1'b1, 1'b0);
    tag = "R2/R3/R1 zero frame";
    sendFrame(1, 0, 1, FRAME);
    tag = "R4/R1 random frame";
    sendFrame(0, 0, 1, FRAME);
    tag = "R5 gaps";
    sendFrame(0, 1, 1, FRAME);
    sendFrame(1, 1, 1, FRAME);
    tag = "R9 flywheel";
    sendFrame(1, 1, 0, FRAME + 20);
    tag = "R10 early resync";
    sendFrame(0, 1, 1, 50);
    sendFrame(1, 0, 1, FRAME);
    tag = "R7 unqualified fs";
    drive(8'h5A, 1'b0, 1'b1);
    sendFrame(1, 0, 0, 30);
    drive(8'h00, 1'b0, 1'b1);
    drive(8'h00, 1'b0, 1'b0);
    tag = "R6 idle hold";
    for (int i = 0; i < 5; i++) drive(8'($urandom), 1'b0, 1'b0);
    sendFrame(0, 1, 1, 2 * FRAME);
    drive(8'h00, 1'b0, 1'b0);
    drive(8'h00, 1'b0, 1'b0);
    @(negedge clk);
    finishRun();
  end

endmodule